// File: doc/BRIEF.md
# DRAM Clock-Frequency-Change Sequencer

This controller-side state machine takes a DDR2-style memory device through a change of its input clock frequency. The change happens while the device is held in precharge power-down. When a request is accepted, the block first turns on-die termination off and lets it settle. It then drops clock enable and keeps both signals low for the minimum hold time. Next it asks an external clock generator to switch, and it waits for two answers from that generator: that the switch is done, then that the new clock is stable.

After the new clock is stable, the block raises clock enable and waits out the power-down exit delay. It then issues a mode-register command that resets the device's DLL. If the caller asked for it, a second mode-register command follows to load latency settings that suit the new clock. The block then holds off everything until the DLL has had its full relock time, and marks the return to normal operation with a one-cycle done pulse.

The caller gives the new clock period and says whether the latency update is wanted. A request is refused when the period lies outside the permitted range or when the banks are not all precharged. A request that arrives while a sequence is running is ignored. Every wait is a parameterised down-counter, and NOP is driven on the command bus in every cycle that is not a mode-register command.

Top module: `ddr_fchg_seq`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, the outputs are in their idle state: `cke_o`=1, `busy_o`=0, `done_o`=0, `reject_o`=0, `clk_chg_req_o`=0 and `cmd_o`=2'b00 (NOP).
- R2: A request is accepted when `req_i` is sampled high while idle, with `banks_idle_i` high and `tck_i` inside [TCK_MIN, TCK_MAX], both limits included. `busy_o` then rises on the next cycle and `clk_tck_o` takes the value of `tck_i`. Any other request sampled while idle leaves `busy_o` low and gives a one-cycle `reject_o` pulse on the next cycle.
- R3: While idle, `odt_o` follows `odt_i`. `odt_o` is 0 in every cycle in which `busy_o` is 1. `cke_o` falls T_AOFD cycles after `busy_o` rises.
- R4: `clk_chg_req_o` rises T_CKE_CHG cycles after `cke_o` falls. It stays high until `clk_ready_i` is sampled high, and it falls on the cycle after that sample.
- R5: From the fall of `cke_o` until `clk_stable_i` is sampled high after the ready answer, `cke_o` and `odt_o` stay 0. `cke_o` rises on the cycle after that stable sample.
- R6: The DLL-reset mode-register command (`cmd_o`=2'b01) appears for one cycle, T_XP cycles after `cke_o` rises.
- R7: If `upd_lat_i` was high when the request was accepted, the latency mode-register command (`cmd_o`=2'b10) appears exactly once, T_MRD+1 cycles after the DLL-reset command. If `upd_lat_i` was low, the latency command does not appear at all.
- R8: `cmd_o` is NOP (2'b00) in every cycle other than the one or two mode-register command cycles of a sequence.
- R9: `done_o` is a one-cycle pulse T_DLLK+1 cycles after the DLL-reset command, so at least T_DLLK NOP cycles lie between them. `busy_o` falls on the cycle after `done_o`.
- R10: A `req_i` sampled while `busy_o` is 1 is ignored. It gives no `reject_o` pulse, `clk_tck_o` keeps its value, the timing of the running sequence does not change, and no new sequence starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a frequency change |
| tck_i | input | TCK_W | New clock period requested |
| upd_lat_i | input | 1 | Issue the latency mode-register command as well |
| banks_idle_i | input | 1 | All banks are precharged |
| odt_i | input | 1 | Normal termination request from the controller |
| clk_ready_i | input | 1 | Clock generator has finished the switch |
| clk_stable_i | input | 1 | The new clock is stable |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination to the device |
| cmd_o | output | 2 | Command: 00 NOP, 01 DLL-reset MRS, 10 latency MRS |
| clk_chg_req_o | output | 1 | Request to the clock generator to switch |
| clk_tck_o | output | TCK_W | Latched target period for the generator |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: normal operation resumes |
| reject_o | output | 1 | One-cycle pulse: request refused |

## Verification
The assertions check on every cycle that termination stays off while the block is busy, and that clock enable and termination stay low for as long as the switch request is up. They also check that the switch request is never raised less than two cycles after clock enable falls, and that clock enable rises only right after a stable indication. Further per-cycle checks cover the following: no mode-register command while clock enable is low, no done pulse until more than T_DLLK cycles after the DLL reset, no rejection while busy, and a requested period always in range. Only the bench scenarios can show the exact spacing between events. These are the delays from acceptance to clock-enable fall, to the request, to the power-down exit and to each command. The scenarios also show that a latency command is present or absent according to the latched flag, that requests at the exact range limits are accepted, and that a request during a running sequence changes nothing.

// File: rtl/fchg_pkg.sv
package fchg_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_MRS_DLL = 2'b01,
    CMD_MRS_LAT = 2'b10
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ODT_OFF,
    ST_PD_HOLD,
    ST_CLK_REQ,
    ST_CLK_STBL,
    ST_XP,
    ST_MRS_DLL,
    ST_MRD,
    ST_MRS_LAT,
    ST_RELOCK,
    ST_DONE
  } state_e;
endpackage

// File: rtl/fchg_timer.sv
module fchg_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fchg_tck_chk.sv
module fchg_tck_chk #(
  parameter int TCK_W   = 16,
  parameter int TCK_MIN = 2500,
  parameter int TCK_MAX = 8000
) (
  input  logic [TCK_W-1:0] tck_i,
  output logic             in_range_o
);
  localparam logic [TCK_W-1:0] MIN_V = TCK_W'(TCK_MIN);
  localparam logic [TCK_W-1:0] MAX_V = TCK_W'(TCK_MAX);

  assign in_range_o = (tck_i >= MIN_V) && (tck_i <= MAX_V);
endmodule

// File: rtl/fchg_fsm.sv
module fchg_fsm
  import fchg_pkg::*;
#(
  parameter int T_AOFD    = 3,
  parameter int T_CKE_CHG = 2,
  parameter int T_XP      = 2,
  parameter int T_MRD     = 2,
  parameter int T_DLLK    = 200,
  parameter int STEP_W    = 2,
  parameter int RLK_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              upd_i,
  input  logic              odt_i,
  input  logic              clk_ready_i,
  input  logic              clk_stable_i,
  input  logic              step_zero_i,
  input  logic              rlk_zero_i,
  output logic              step_load_o,
  output logic [STEP_W-1:0] step_val_o,
  output logic              rlk_load_o,
  output logic [RLK_W-1:0]  rlk_val_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic [1:0]        cmd_o,
  output logic              clk_chg_req_o,
  output logic              busy_o,
  output logic              done_o
);
  state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    step_load_o = 1'b0;
    step_val_o  = '0;
    rlk_load_o  = 1'b0;
    rlk_val_o   = RLK_W'(T_DLLK - 1);
    unique case (st_q)
      ST_IDLE: if (accept_i) begin
        st_d        = ST_ODT_OFF;
        step_load_o = 1'b1;
        step_val_o  = STEP_W'(T_AOFD - 1);
      end
      ST_ODT_OFF: if (step_zero_i) begin
        st_d        = ST_PD_HOLD;
        step_load_o = 1'b1;
        step_val_o  = STEP_W'(T_CKE_CHG - 1);
      end
      ST_PD_HOLD:  if (step_zero_i) st_d = ST_CLK_REQ;
      ST_CLK_REQ:  if (clk_ready_i) st_d = ST_CLK_STBL;
      ST_CLK_STBL: if (clk_stable_i) begin
        st_d        = ST_XP;
        step_load_o = 1'b1;
        step_val_o  = STEP_W'(T_XP - 1);
      end
      ST_XP: if (step_zero_i) st_d = ST_MRS_DLL;
      ST_MRS_DLL: begin
        rlk_load_o = 1'b1;
        if (upd_i) begin
          st_d        = ST_MRD;
          step_load_o = 1'b1;
          step_val_o  = STEP_W'(T_MRD - 1);
        end else begin
          st_d = ST_RELOCK;
        end
      end
      ST_MRD:     if (step_zero_i) st_d = ST_MRS_LAT;
      ST_MRS_LAT: st_d = ST_RELOCK;
      ST_RELOCK:  if (rlk_zero_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // Device side is Moore-decoded from the state
  always_comb begin
    cke_o         = !(st_q inside {ST_PD_HOLD, ST_CLK_REQ, ST_CLK_STBL});
    odt_o         = (st_q == ST_IDLE) ? odt_i : 1'b0;
    clk_chg_req_o = (st_q == ST_CLK_REQ);
    busy_o        = (st_q != ST_IDLE);
    done_o        = (st_q == ST_DONE);
    unique case (st_q)
      ST_MRS_DLL: cmd_o = CMD_MRS_DLL;
      ST_MRS_LAT: cmd_o = CMD_MRS_LAT;
      default:    cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr_fchg_seq.sv
module ddr_fchg_seq #(
  parameter int TCK_W     = 16,
  parameter int TCK_MIN   = 2500,
  parameter int TCK_MAX   = 8000,
  parameter int T_AOFD    = 3,
  parameter int T_CKE_CHG = 2,
  parameter int T_XP      = 2,
  parameter int T_MRD     = 2,
  parameter int T_DLLK    = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [TCK_W-1:0] tck_i,
  input  logic             upd_lat_i,
  input  logic             banks_idle_i,
  input  logic             odt_i,
  input  logic             clk_ready_i,
  input  logic             clk_stable_i,
  output logic             cke_o,
  output logic             odt_o,
  output logic [1:0]       cmd_o,
  output logic             clk_chg_req_o,
  output logic [TCK_W-1:0] clk_tck_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             reject_o
);
  localparam int STEP_MAX1 = (T_AOFD > T_CKE_CHG) ? T_AOFD : T_CKE_CHG;
  localparam int STEP_MAX2 = (T_XP > T_MRD) ? T_XP : T_MRD;
  localparam int STEP_MAX  = (STEP_MAX1 > STEP_MAX2) ? STEP_MAX1 : STEP_MAX2;
  localparam int STEP_W    = $clog2(STEP_MAX + 1);
  localparam int RLK_W     = $clog2(T_DLLK + 1);

  logic              in_range, accept;
  logic              step_load, step_zero, rlk_load, rlk_zero;
  logic [STEP_W-1:0] step_val;
  logic [RLK_W-1:0]  rlk_val;
  logic [TCK_W-1:0]  tck_q;
  logic              upd_q, reject_q;

  fchg_tck_chk #(.TCK_W(TCK_W), .TCK_MIN(TCK_MIN), .TCK_MAX(TCK_MAX)) u_rng (
    .tck_i      (tck_i),
    .in_range_o (in_range)
  );

  assign accept = req_i && !busy_o && in_range && banks_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q    <= '0;
      upd_q    <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= req_i && !busy_o && !(in_range && banks_idle_i);
      if (accept) begin
        tck_q <= tck_i;
        upd_q <= upd_lat_i;
      end
    end
  end

  fchg_timer #(.W(STEP_W)) u_step (
    .clk_i, .rst_ni, .load_i(step_load), .val_i(step_val), .zero_o(step_zero)
  );

  fchg_timer #(.W(RLK_W)) u_rlk (
    .clk_i, .rst_ni, .load_i(rlk_load), .val_i(rlk_val), .zero_o(rlk_zero)
  );

  fchg_fsm #(
    .T_AOFD(T_AOFD), .T_CKE_CHG(T_CKE_CHG), .T_XP(T_XP), .T_MRD(T_MRD),
    .T_DLLK(T_DLLK), .STEP_W(STEP_W), .RLK_W(RLK_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .accept_i      (accept),
    .upd_i         (upd_q),
    .odt_i         (odt_i),
    .clk_ready_i   (clk_ready_i),
    .clk_stable_i  (clk_stable_i),
    .step_zero_i   (step_zero),
    .rlk_zero_i    (rlk_zero),
    .step_load_o   (step_load),
    .step_val_o    (step_val),
    .rlk_load_o    (rlk_load),
    .rlk_val_o     (rlk_val),
    .cke_o         (cke_o),
    .odt_o         (odt_o),
    .cmd_o         (cmd_o),
    .clk_chg_req_o (clk_chg_req_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  assign clk_tck_o = tck_q;
  assign reject_o  = reject_q;
endmodule

// File: rtl/fchg_checker.sv
module fchg_checker #(
  parameter int TCK_W   = 16,
  parameter int TCK_MIN = 2500,
  parameter int TCK_MAX = 8000,
  parameter int T_DLLK  = 200
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_stable_i,
  input logic             cke_o,
  input logic             odt_o,
  input logic [1:0]       cmd_o,
  input logic             clk_chg_req_o,
  input logic [TCK_W-1:0] clk_tck_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             reject_o
);
  localparam int CW = $clog2(T_DLLK + 3) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since_dll;
  logic          dll_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_dll <= '0;
      dll_seen  <= 1'b0;
    end else if (cmd_o == 2'b01) begin
      since_dll <= CW'(1);
      dll_seen  <= 1'b1;
    end else if (since_dll != CMAX) begin
      since_dll <= since_dll + 1'b1;
    end
  end

  a_r3_odt_off_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !odt_o);
  a_r5_freeze_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_chg_req_o |-> (!cke_o && !odt_o));
  a_r4_cke_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_chg_req_o) |-> (!$past(cke_o) && !$past(cke_o, 2)));
  a_r5_exit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));
  a_r6_cmd_cke_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 2'b00) |-> (cke_o && $past(cke_o)));
  a_r8_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 2'b11);
  a_r9_relock_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dll_seen && (since_dll > CW'(T_DLLK))));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_tck_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_chg_req_o |-> ((clk_tck_o >= TCK_W'(TCK_MIN)) && (clk_tck_o <= TCK_W'(TCK_MAX))));
  a_r10_no_reject_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !busy_o);
endmodule

bind ddr_fchg_seq fchg_checker #(
  .TCK_W(TCK_W), .TCK_MIN(TCK_MIN), .TCK_MAX(TCK_MAX), .T_DLLK(T_DLLK)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_stable_i  (clk_stable_i),
  .cke_o         (cke_o),
  .odt_o         (odt_o),
  .cmd_o         (cmd_o),
  .clk_chg_req_o (clk_chg_req_o),
  .clk_tck_o     (clk_tck_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .reject_o      (reject_o)
);

// File: tb/sim_ddr_fchg_seq.sv
`timescale 1ns/1ps
module sim_ddr_fchg_seq;
  localparam int TCK_W = 16, TCK_MIN = 2500, TCK_MAX = 8000;
  localparam int T_AOFD = 3, T_CKE_CHG = 2, T_XP = 2, T_MRD = 2, T_DLLK = 200;

  logic clk = 0, rst_n = 0;
  logic req = 0, upd = 0, banks = 1, odt_in = 1, ready = 0, stable = 1;
  logic [TCK_W-1:0] tck = '0;
  logic cke, odt, chg_req, busy, done, reject;
  logic [1:0] cmd;
  logic [TCK_W-1:0] tck_out;

  always #2 clk = ~clk;

  ddr_fchg_seq #(
    .TCK_W(TCK_W), .TCK_MIN(TCK_MIN), .TCK_MAX(TCK_MAX), .T_AOFD(T_AOFD),
    .T_CKE_CHG(T_CKE_CHG), .T_XP(T_XP), .T_MRD(T_MRD), .T_DLLK(T_DLLK)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .tck_i(tck), .upd_lat_i(upd),
    .banks_idle_i(banks), .odt_i(odt_in), .clk_ready_i(ready),
    .clk_stable_i(stable), .cke_o(cke), .odt_o(odt), .cmd_o(cmd),
    .clk_chg_req_o(chg_req), .clk_tck_o(tck_out), .busy_o(busy),
    .done_o(done), .reject_o(reject)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int busy_rise_c, busy_fall_c, odt_fall_c, cke_fall_c, cke_rise_c;
  int req_rise_c, req_fall_c, ready_c, stable_c, dll_c, lat_c, done_c;
  int lat_n, cmd_n, viol_n, done_n;
  int rdy_dly = 2, stb_dly = 3, rdy_cnt = 0, stb_cnt = 0;
  bit pend = 0;
  logic p_cke = 1, p_busy = 0, p_odt = 0, p_req = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_ev();
    busy_rise_c = -1; busy_fall_c = -1; odt_fall_c = -1; cke_fall_c = -1;
    cke_rise_c = -1; req_rise_c = -1; req_fall_c = -1; ready_c = -1;
    stable_c = -1; dll_c = -1; lat_c = -1; done_c = -1;
    lat_n = 0; cmd_n = 0; viol_n = 0; done_n = 0;
  endtask

  // Monitor and clock-generator model, both at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (busy && !p_busy) busy_rise_c = cyc;
    if (!busy && p_busy) busy_fall_c = cyc;
    if (!odt && p_odt)   odt_fall_c = cyc;
    if (!cke && p_cke)   cke_fall_c = cyc;
    if (cke && !p_cke)   cke_rise_c = cyc;
    if (chg_req && !p_req) req_rise_c = cyc;
    if (!chg_req && p_req) req_fall_c = cyc;
    if (cmd == 2'b01) dll_c = cyc;
    if (cmd == 2'b10) begin lat_c = cyc; lat_n++; end
    if (cmd != 2'b00) cmd_n++;
    if (done) begin done_c = cyc; done_n++; end
    if ((busy && odt) || (chg_req && (cke || odt))) viol_n++;
    p_cke = cke; p_busy = busy; p_odt = odt; p_req = chg_req;
    if (chg_req && !ready) begin
      stable = 0;
      if (rdy_cnt >= rdy_dly) begin ready = 1; rdy_cnt = 0; ready_c = cyc; end
      else rdy_cnt++;
    end else if (!chg_req && ready) begin
      ready = 0; pend = 1; stb_cnt = 0;
    end else if (pend) begin
      stb_cnt++;
      if (stb_cnt >= stb_dly) begin stable = 1; pend = 0; stable_c = cyc; end
    end
  end

  task automatic pulse_req(input int t, input bit u, output int k);
    @(negedge clk); #1;
    req = 1; tck = TCK_W'(t); upd = u; k = cyc;
    @(negedge clk); #1;
    req = 0;
  endtask

  task automatic t_reset();
    chk("R1 cke", int'(cke), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 reject", int'(reject), 0);
    chk("R1 chg_req", int'(chg_req), 0);
    chk("R1 cmd", int'(cmd), 0);
    chk("R3 odt idle pass", int'(odt), 1);
  endtask

  task automatic t_reject(input int t, input bit bk, input string tag);
    int k;
    banks = bk;
    pulse_req(t, 0, k);
    chk({tag, " reject pulse"}, int'(reject), 1);
    chk({tag, " no busy"}, int'(busy), 0);
    @(negedge clk); #1;
    chk({tag, " reject one cycle"}, int'(reject), 0);
    chk({tag, " still idle"}, int'(busy), 0);
    banks = 1;
  endtask

  task automatic t_seq(input int t, input bit u, input int rd, input int sd, input bit poke);
    int k, k2;
    logic [TCK_W-1:0] tck_keep;
    clr_ev();
    rdy_dly = rd; stb_dly = sd; odt_in = 1;
    pulse_req(t, u, k);
    chk("R2 busy rise", busy_rise_c, k + 1);
    chk("R2 tck latched", int'(tck_out), t);
    chk("R3 odt drop", odt_fall_c, k + 1);
    while (dll_c < 0) @(negedge clk);
    if (poke) begin
      tck_keep = tck_out;
      pulse_req(TCK_MIN + 1, !u, k2);
      chk("R10 no reject busy", int'(reject), 0);
      chk("R10 tck kept", int'(tck_out), int'(tck_keep));
    end
    while (done_c < 0) @(negedge clk);
    @(negedge clk); #1;
    chk("R3 cke fall spacing", cke_fall_c - busy_rise_c, T_AOFD);
    chk("R4 req after cke low", req_rise_c - cke_fall_c, T_CKE_CHG);
    chk("R4 req drop after ready", req_fall_c - ready_c, 1);
    chk("R5 cke rise after stable", cke_rise_c - stable_c, 1);
    chk("R5 freeze violations", viol_n, 0);
    chk("R6 dll after xp", dll_c - cke_rise_c, T_XP);
    if (u) chk("R7 lat spacing", lat_c - dll_c, T_MRD + 1);
    chk("R7 lat count", lat_n, u ? 1 : 0);
    chk("R8 cmd cycles", cmd_n, u ? 2 : 1);
    chk("R9 done spacing", done_c - dll_c, T_DLLK + 1);
    chk("R9 done single", done_n, 1);
    chk("R9 busy fall", busy_fall_c, done_c + 1);
    chk("R3 odt pass after", int'(odt), 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      #1;
      chk("R10 no restart", int'(busy), 0);
    end
  endtask

  initial begin
    clr_ev();
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_reject(TCK_MIN - 1, 1, "R2 below min");
    t_reject(TCK_MAX + 1, 1, "R2 above max");
    t_reject(5000, 0, "R2 banks busy");
    t_seq(TCK_MIN, 1, 2, 3, 0);
    t_seq(TCK_MAX, 0, 0, 1, 0);
    t_seq(4000, 1, 5, 7, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule